// File: doc/BRIEF.md
# Self-Refresh Exit Cycle Partitioner

This block sits beside a memory command monitor and charges the time a memory device spends in self-refresh to a set of cycle buckets. An entry strobe stamps the current timestamp, raises the in-self-refresh mode and counts the entry. An exit strobe measures the time since the stored entry stamp and sorts it against two limits: the full refresh time tRFC and its active part tRFC − tRP. The class decides how the measured time is split between the buckets. These are the active part and the precharge part of the first internal refresh, plain self-refresh residence, and the active and precharge parts of that refresh still running after the exit.

The exit also adds a wake-up penalty to its own bucket. With the delay-locked loop disabled the penalty is tXS. With it enabled the penalty is tXSDLL − tRCD. In the two short classes, the refresh cycles already charged after the exit are taken off the penalty, which never drops below zero. A last-precharge timestamp output moves to the point where the device is precharged again.

The exit is handled in two registered steps. The classification is captured on the clock edge that samples the exit strobe. The buckets commit on the following edge, with a one-cycle done pulse. Warning and error flags are valid only during that pulse.

Top module: `sref_exit_partitioner`

## Requirements
- R1: After reset every counter, `last_pre_o`, the stored entry stamp, `in_sref_o`, `done_o` and all flags are zero.
- R2: An `enter_i` strobe stores `ts_i` as the entry stamp, increments `sref_cnt_o` by one and sets `in_sref_o`, all visible after the sampling edge.
- R3: An `exit_i` strobe without `enter_i` clears `in_sref_o` after its sampling edge. `done_o` is high for exactly the cycle after the following edge, and all buckets and `last_pre_o` change at that same edge and at no other.
- R4: The duration is the exit `ts_i` minus the stored entry stamp. When the exit stamp is not greater than the entry stamp, the duration is taken as 0 and `warn_zero_o` is high with `done_o`.
- R5: `warn_ckesr_o` is high with `done_o` when the (clamped) duration is below tCKESR.
- R6: Long class (duration ≥ tRFC): refresh-active grows by tRFC − tRP, refresh-precharge by tRP, and self-refresh residence by duration − tRFC. Both post-exit buckets are unchanged, and `last_pre_o` becomes the exit stamp.
- R7: Middle class (tRFC − tRP ≤ duration < tRFC), with p = duration − (tRFC − tRP): refresh-active grows by tRFC − tRP, refresh-precharge by p, and post-exit precharge by tRP − p. `last_pre_o` becomes the exit stamp + tRP − p.
- R8: Short class (duration < tRFC − tRP): refresh-active grows by the duration, post-exit active by tRFC − tRP − duration, and post-exit precharge by tRP. `last_pre_o` becomes the exit stamp + tRFC − duration.
- R9: The penalty bucket grows by a base minus the post-exit cycles charged by this exit, saturating at 0. The base is tXS when `dll_en_i` = 0 and tXSDLL − tRCD when it is 1.
- R10: An exit sampled while `in_sref_o` is 0 raises `err_state_o` with `done_o`. The exit is still accounted against the last stored entry stamp.
- R11: When `enter_i` and `exit_i` are sampled on the same edge, the exit is measured from the previous entry stamp. The new stamp is then stored, the count increments and `in_sref_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_i | input | 1 | Self-refresh entry strobe |
| exit_i | input | 1 | Self-refresh exit strobe |
| ts_i | input | TS_W | Timestamp of the strobe |
| dll_en_i | input | 1 | Delay-locked loop enabled, selects penalty base |
| t_rfc_i | input | CFG_W | Refresh cycle time |
| t_rp_i | input | CFG_W | Precharge time |
| t_ckesr_i | input | CFG_W | Minimum self-refresh residence |
| t_xs_i | input | CFG_W | Exit time, loop disabled |
| t_xsdll_i | input | CFG_W | Exit time, loop enabled |
| t_rcd_i | input | CFG_W | Activate-to-access time |
| in_sref_o | output | 1 | Mode is self-refresh |
| sref_cnt_o | output | CNT_W | Number of entries |
| done_o | output | 1 | Bucket commit pulse |
| warn_zero_o | output | 1 | Non-positive duration (with done) |
| warn_ckesr_o | output | 1 | Duration below tCKESR (with done) |
| err_state_o | output | 1 | Exit outside self-refresh (with done) |
| ref_act_o | output | CNT_W | Refresh-active cycles inside self-refresh |
| ref_pre_o | output | CNT_W | Refresh-precharge cycles inside self-refresh |
| sref_cyc_o | output | CNT_W | Plain self-refresh residence cycles |
| pup_act_o | output | CNT_W | Refresh-active cycles after exit |
| pup_pre_o | output | CNT_W | Refresh-precharge cycles after exit |
| pen_o | output | CNT_W | Accumulated exit penalty |
| last_pre_o | output | TS_W | Time the device is precharged again |

## Verification
Two functions can meet in one cycle: an entry strobe and an exit strobe sampled together, and an entry strobe landing in the commit cycle of the previous exit. The bench drives both on purpose. In the first case it judges that the exit is charged against the old stamp while the new stamp, the count and the mode all take the entry. In the second it checks the committed buckets and the new entry together, then sends a later exit whose duration must be measured from the newer stamp. A sweep over every duration around both class limits, with both loop settings, covers the three-way split and the penalty saturation.

// File: rtl/sref_part_pkg.sv
package sref_part_pkg;
    typedef enum logic [1:0] {
        CLS_SHORT = 2'd0,
        CLS_MID   = 2'd1,
        CLS_LONG  = 2'd2
    } dur_cls_e;
endpackage

// File: rtl/sref_dur_classifier.sv
module sref_dur_classifier
    import sref_part_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CFG_W = 16
) (
    input  logic [TS_W-1:0]  entry_ts_i,
    input  logic [TS_W-1:0]  exit_ts_i,
    input  logic [CFG_W-1:0] t_rfc_i,
    input  logic [CFG_W-1:0] t_rp_i,
    input  logic [CFG_W-1:0] t_ckesr_i,
    output logic [TS_W-1:0]  dur_o,
    output dur_cls_e         cls_o,
    output logic             warn_zero_o,
    output logic             warn_ckesr_o
);
    localparam int PAD = TS_W - CFG_W;

    logic [TS_W-1:0] rfc_w, rp_w, act_w, ckesr_w;

    always_comb begin
        rfc_w   = {{PAD{1'b0}}, t_rfc_i};
        rp_w    = {{PAD{1'b0}}, t_rp_i};
        ckesr_w = {{PAD{1'b0}}, t_ckesr_i};
        act_w   = (rfc_w > rp_w) ? (rfc_w - rp_w) : '0;

        warn_zero_o = (exit_ts_i <= entry_ts_i);
        dur_o       = warn_zero_o ? '0 : (exit_ts_i - entry_ts_i);
        warn_ckesr_o = (dur_o < ckesr_w);

        if (dur_o >= rfc_w) begin
            cls_o = CLS_LONG;
        end else if (dur_o >= act_w) begin
            cls_o = CLS_MID;
        end else begin
            cls_o = CLS_SHORT;
        end
    end
endmodule

// File: rtl/sref_bucket_split.sv
module sref_bucket_split
    import sref_part_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CFG_W = 16
) (
    input  dur_cls_e         cls_i,
    input  logic [TS_W-1:0]  dur_i,
    input  logic [TS_W-1:0]  exit_ts_i,
    input  logic             dll_en_i,
    input  logic [CFG_W-1:0] t_rfc_i,
    input  logic [CFG_W-1:0] t_rp_i,
    input  logic [CFG_W-1:0] t_xs_i,
    input  logic [CFG_W-1:0] t_xsdll_i,
    input  logic [CFG_W-1:0] t_rcd_i,
    output logic [TS_W-1:0]  inc_ref_act_o,
    output logic [TS_W-1:0]  inc_ref_pre_o,
    output logic [TS_W-1:0]  inc_sref_o,
    output logic [TS_W-1:0]  inc_pup_act_o,
    output logic [TS_W-1:0]  inc_pup_pre_o,
    output logic [TS_W-1:0]  inc_pen_o,
    output logic [TS_W-1:0]  last_pre_o
);
    localparam int PAD = TS_W - CFG_W;

    function automatic logic [TS_W-1:0] sat_sub(input logic [TS_W-1:0] a,
                                                input logic [TS_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    logic [TS_W-1:0] rfc_w, rp_w, act_w, base_w, part_w, tail_w;

    always_comb begin
        rfc_w  = {{PAD{1'b0}}, t_rfc_i};
        rp_w   = {{PAD{1'b0}}, t_rp_i};
        act_w  = sat_sub(rfc_w, rp_w);
        base_w = dll_en_i ? sat_sub({{PAD{1'b0}}, t_xsdll_i}, {{PAD{1'b0}}, t_rcd_i})
                          : {{PAD{1'b0}}, t_xs_i};
        part_w = '0;
        tail_w = '0;

        inc_ref_act_o = '0;
        inc_ref_pre_o = '0;
        inc_sref_o    = '0;
        inc_pup_act_o = '0;
        inc_pup_pre_o = '0;
        inc_pen_o     = base_w;
        last_pre_o    = exit_ts_i;

        unique case (cls_i)
            CLS_LONG: begin
                inc_ref_act_o = act_w;
                inc_ref_pre_o = rp_w;
                inc_sref_o    = dur_i - rfc_w;
            end
            CLS_MID: begin
                part_w        = dur_i - act_w;
                tail_w        = rp_w - part_w;
                inc_ref_act_o = act_w;
                inc_ref_pre_o = part_w;
                inc_pup_pre_o = tail_w;
                inc_pen_o     = sat_sub(base_w, tail_w);
                last_pre_o    = exit_ts_i + tail_w;
            end
            default: begin
                part_w        = act_w - dur_i;
                inc_ref_act_o = dur_i;
                inc_pup_act_o = part_w;
                inc_pup_pre_o = rp_w;
                inc_pen_o     = sat_sub(base_w, part_w + rp_w);
                last_pre_o    = exit_ts_i + part_w + rp_w;
            end
        endcase
    end
endmodule

// File: rtl/sref_exit_partitioner.sv
module sref_exit_partitioner
    import sref_part_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int CFG_W = 16,
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter_i,
    input  logic             exit_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic             dll_en_i,
    input  logic [CFG_W-1:0] t_rfc_i,
    input  logic [CFG_W-1:0] t_rp_i,
    input  logic [CFG_W-1:0] t_ckesr_i,
    input  logic [CFG_W-1:0] t_xs_i,
    input  logic [CFG_W-1:0] t_xsdll_i,
    input  logic [CFG_W-1:0] t_rcd_i,
    output logic             in_sref_o,
    output logic [CNT_W-1:0] sref_cnt_o,
    output logic             done_o,
    output logic             warn_zero_o,
    output logic             warn_ckesr_o,
    output logic             err_state_o,
    output logic [CNT_W-1:0] ref_act_o,
    output logic [CNT_W-1:0] ref_pre_o,
    output logic [CNT_W-1:0] sref_cyc_o,
    output logic [CNT_W-1:0] pup_act_o,
    output logic [CNT_W-1:0] pup_pre_o,
    output logic [CNT_W-1:0] pen_o,
    output logic [TS_W-1:0]  last_pre_o
);
    typedef struct packed {
        logic [TS_W-1:0]  entry_ts;
        logic             in_sref;
        logic [CNT_W-1:0] sref_cnt;
        logic             s1_vld;
        dur_cls_e         s1_cls;
        logic [TS_W-1:0]  s1_dur;
        logic [TS_W-1:0]  s1_ts;
        logic             s1_wz;
        logic             s1_wc;
        logic             s1_err;
        logic             done;
        logic             wz;
        logic             wc;
        logic             err;
        logic [CNT_W-1:0] ref_act;
        logic [CNT_W-1:0] ref_pre;
        logic [CNT_W-1:0] sref_cyc;
        logic [CNT_W-1:0] pup_act;
        logic [CNT_W-1:0] pup_pre;
        logic [CNT_W-1:0] pen;
        logic [TS_W-1:0]  last_pre;
    } part_st_t;

    part_st_t st_d, st_q;

    logic [TS_W-1:0] cl_dur;
    dur_cls_e        cl_cls;
    logic            cl_wz, cl_wc;
    logic [TS_W-1:0] inc_ra, inc_rp, inc_sr, inc_pa, inc_pp, inc_pen, nxt_last;

    sref_dur_classifier #(.TS_W(TS_W), .CFG_W(CFG_W)) u_cls (
        .entry_ts_i   (st_q.entry_ts),
        .exit_ts_i    (ts_i),
        .t_rfc_i      (t_rfc_i),
        .t_rp_i       (t_rp_i),
        .t_ckesr_i    (t_ckesr_i),
        .dur_o        (cl_dur),
        .cls_o        (cl_cls),
        .warn_zero_o  (cl_wz),
        .warn_ckesr_o (cl_wc)
    );

    sref_bucket_split #(.TS_W(TS_W), .CFG_W(CFG_W)) u_split (
        .cls_i         (st_q.s1_cls),
        .dur_i         (st_q.s1_dur),
        .exit_ts_i     (st_q.s1_ts),
        .dll_en_i      (dll_en_i),
        .t_rfc_i       (t_rfc_i),
        .t_rp_i        (t_rp_i),
        .t_xs_i        (t_xs_i),
        .t_xsdll_i     (t_xsdll_i),
        .t_rcd_i       (t_rcd_i),
        .inc_ref_act_o (inc_ra),
        .inc_ref_pre_o (inc_rp),
        .inc_sref_o    (inc_sr),
        .inc_pup_act_o (inc_pa),
        .inc_pup_pre_o (inc_pp),
        .inc_pen_o     (inc_pen),
        .last_pre_o    (nxt_last)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wz   = 1'b0;
        st_d.wc   = 1'b0;
        st_d.err  = 1'b0;

        // commit step: buckets follow the exit captured one edge earlier
        if (st_q.s1_vld) begin
            st_d.done     = 1'b1;
            st_d.wz       = st_q.s1_wz;
            st_d.wc       = st_q.s1_wc;
            st_d.err      = st_q.s1_err;
            st_d.ref_act  = st_q.ref_act  + CNT_W'(inc_ra);
            st_d.ref_pre  = st_q.ref_pre  + CNT_W'(inc_rp);
            st_d.sref_cyc = st_q.sref_cyc + CNT_W'(inc_sr);
            st_d.pup_act  = st_q.pup_act  + CNT_W'(inc_pa);
            st_d.pup_pre  = st_q.pup_pre  + CNT_W'(inc_pp);
            st_d.pen      = st_q.pen      + CNT_W'(inc_pen);
            st_d.last_pre = nxt_last;
        end

        // capture step: registered classification of the exit
        st_d.s1_vld = exit_i;
        if (exit_i) begin
            st_d.s1_cls  = cl_cls;
            st_d.s1_dur  = cl_dur;
            st_d.s1_ts   = ts_i;
            st_d.s1_wz   = cl_wz;
            st_d.s1_wc   = cl_wc;
            st_d.s1_err  = ~st_q.in_sref;
            st_d.in_sref = 1'b0;
        end

        // entry wins the mode when both strobes meet
        if (enter_i) begin
            st_d.entry_ts = ts_i;
            st_d.sref_cnt = st_q.sref_cnt + 1'b1;
            st_d.in_sref  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_sref_o    = st_q.in_sref;
    assign sref_cnt_o   = st_q.sref_cnt;
    assign done_o       = st_q.done;
    assign warn_zero_o  = st_q.wz;
    assign warn_ckesr_o = st_q.wc;
    assign err_state_o  = st_q.err;
    assign ref_act_o    = st_q.ref_act;
    assign ref_pre_o    = st_q.ref_pre;
    assign sref_cyc_o   = st_q.sref_cyc;
    assign pup_act_o    = st_q.pup_act;
    assign pup_pre_o    = st_q.pup_pre;
    assign pen_o        = st_q.pen;
    assign last_pre_o   = st_q.last_pre;
endmodule

// File: rtl/sref_part_chk.sv
module sref_part_chk #(
    parameter int CNT_W = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enter_i,
    input logic             exit_i,
    input logic             in_sref_o,
    input logic [CNT_W-1:0] sref_cnt_o,
    input logic             done_o,
    input logic             warn_zero_o,
    input logic             warn_ckesr_o,
    input logic             err_state_o,
    input logic [CNT_W-1:0] ref_act_o,
    input logic [CNT_W-1:0] pup_act_o,
    input logic [CNT_W-1:0] pup_pre_o
);
    // R2
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> in_sref_o);

    // R2
    entry_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_i |=> (sref_cnt_o == $past(sref_cnt_o) + 1'b1));

    // R3
    exit_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !enter_i) |=> !in_sref_o);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exit_i |=> ##1 done_o);

    // R3
    quiet_bucket_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(ref_act_o) && $stable(pup_act_o) && $stable(pup_pre_o)));

    // R4
    flag_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_zero_o || warn_ckesr_o || err_state_o) |-> done_o);

    // R10
    stray_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_i && !in_sref_o) |=> ##1 err_state_o);
endmodule

bind sref_exit_partitioner sref_part_chk #(.CNT_W(CNT_W)) u_part_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_i      (enter_i),
    .exit_i       (exit_i),
    .in_sref_o    (in_sref_o),
    .sref_cnt_o   (sref_cnt_o),
    .done_o       (done_o),
    .warn_zero_o  (warn_zero_o),
    .warn_ckesr_o (warn_ckesr_o),
    .err_state_o  (err_state_o),
    .ref_act_o    (ref_act_o),
    .pup_act_o    (pup_act_o),
    .pup_pre_o    (pup_pre_o)
);

// File: tb/sref_exit_partitioner_tb.sv
module sref_exit_partitioner_tb;
    localparam int TS_W  = 32;
    localparam int CFG_W = 16;
    localparam int CNT_W = 40;

    localparam longint RFC = 10, RP = 3, CKESR = 4, XS = 8, XSDLL = 20, RCD = 5;
    localparam longint ACT = RFC - RP;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enter_i = 1'b0, exit_i = 1'b0, dll_en_i = 1'b0;
    logic [TS_W-1:0]  ts_i = '0;
    logic             in_sref_o, done_o, warn_zero_o, warn_ckesr_o, err_state_o;
    logic [CNT_W-1:0] sref_cnt_o, ref_act_o, ref_pre_o, sref_cyc_o, pup_act_o, pup_pre_o, pen_o;
    logic [TS_W-1:0]  last_pre_o;

    always #5 clk = ~clk;

    sref_exit_partitioner #(.TS_W(TS_W), .CFG_W(CFG_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enter_i(enter_i), .exit_i(exit_i), .ts_i(ts_i),
        .dll_en_i(dll_en_i),
        .t_rfc_i(CFG_W'(RFC)), .t_rp_i(CFG_W'(RP)), .t_ckesr_i(CFG_W'(CKESR)),
        .t_xs_i(CFG_W'(XS)), .t_xsdll_i(CFG_W'(XSDLL)), .t_rcd_i(CFG_W'(RCD)),
        .in_sref_o(in_sref_o), .sref_cnt_o(sref_cnt_o), .done_o(done_o),
        .warn_zero_o(warn_zero_o), .warn_ckesr_o(warn_ckesr_o), .err_state_o(err_state_o),
        .ref_act_o(ref_act_o), .ref_pre_o(ref_pre_o), .sref_cyc_o(sref_cyc_o),
        .pup_act_o(pup_act_o), .pup_pre_o(pup_pre_o), .pen_o(pen_o), .last_pre_o(last_pre_o)
    );

    int checks = 0, failures = 0;
    longint m_entry = 0, m_cnt = 0;
    longint m_ra = 0, m_rp = 0, m_sr = 0, m_pa = 0, m_pp = 0, m_pen = 0, m_last = 0;
    bit     m_in = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic longint sat0(input longint v);
        return (v < 0) ? 0 : v;
    endfunction

    // Model of one exit, from the requirements; returns flags
    task automatic model_exit(input longint ts, input bit dll,
                              output bit wz, output bit wc, output bit er);
        longint d, base, p;
        wz = (ts <= m_entry);
        d  = wz ? 0 : ts - m_entry;
        wc = (d < CKESR);
        er = !m_in;
        base = dll ? (XSDLL - RCD) : XS;
        if (d >= RFC) begin                       // R6
            m_ra += ACT; m_rp += RP; m_sr += d - RFC;
            m_pen += base; m_last = ts;
        end else if (d >= ACT) begin              // R7
            p = d - ACT;
            m_ra += ACT; m_rp += p; m_pp += RP - p;
            m_pen += sat0(base - (RP - p)); m_last = ts + RP - p;
        end else begin                            // R8
            m_ra += d; m_pa += ACT - d; m_pp += RP;
            m_pen += sat0(base - (ACT - d) - RP); m_last = ts + ACT - d + RP;
        end
    endtask

    task automatic check_buckets(input string req);
        chk_eq({req, " ref_act"},  longint'(ref_act_o),  m_ra);
        chk_eq({req, " ref_pre"},  longint'(ref_pre_o),  m_rp);
        chk_eq({req, " sref_cyc"}, longint'(sref_cyc_o), m_sr);
        chk_eq({req, " pup_act"},  longint'(pup_act_o),  m_pa);
        chk_eq({req, " pup_pre"},  longint'(pup_pre_o),  m_pp);
        chk_eq({req, " R9 pen"},   longint'(pen_o),      m_pen);
        chk_eq({req, " last_pre"}, longint'(last_pre_o), m_last);
    endtask

    task automatic do_enter(input longint ts);
        @(negedge clk);
        enter_i = 1'b1; ts_i = TS_W'(ts);
        @(negedge clk);
        enter_i = 1'b0;
        m_entry = ts; m_cnt++; m_in = 1;
        chk_eq("R2 in_sref", longint'(in_sref_o), 1);
        chk_eq("R2 count", longint'(sref_cnt_o), m_cnt);
    endtask

    task automatic do_exit(input longint ts, input bit dll);
        bit wz, wc, er;
        @(negedge clk);
        dll_en_i = dll; exit_i = 1'b1; ts_i = TS_W'(ts);
        model_exit(ts, dll, wz, wc, er);
        m_in = 0;
        @(negedge clk);
        exit_i = 1'b0;
        chk_eq("R3 mode cleared", longint'(in_sref_o), 0);
        chk_eq("R3 no early done", longint'(done_o), 0);
        @(negedge clk);
        chk_eq("R3 done", longint'(done_o), 1);
        chk_eq("R4 warn_zero", longint'(warn_zero_o), longint'(wz));
        chk_eq("R5 warn_ckesr", longint'(warn_ckesr_o), longint'(wc));
        chk_eq("R10 err", longint'(err_state_o), longint'(er));
        check_buckets("R6/R7/R8");
        @(negedge clk);
        chk_eq("R3 done one cycle", longint'(done_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        bit wz, wc, er;
        longint t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 in_sref", longint'(in_sref_o), 0);
        chk_eq("R1 count", longint'(sref_cnt_o), 0);
        chk_eq("R1 done", longint'(done_o), 0);
        check_buckets("R1");

        // Sweep durations around both class limits, both loop settings
        t = 1000;
        for (int dll = 0; dll < 2; dll++) begin
            for (int d = -2; d <= 15; d++) begin
                do_enter(t);
                do_exit(t + d, dll[0]);
                t += 100;
            end
        end

        // R10: exit with no entry, accounted from last stored stamp
        do_exit(t, 1'b0);

        // R11: entry and exit sampled together
        do_enter(t + 100);
        @(negedge clk);
        enter_i = 1'b1; exit_i = 1'b1; ts_i = TS_W'(t + 108); dll_en_i = 1'b0;
        model_exit(t + 108, 1'b0, wz, wc, er);
        m_entry = t + 108; m_cnt++; m_in = 1;
        @(negedge clk);
        enter_i = 1'b0; exit_i = 1'b0;
        chk_eq("R11 mode kept", longint'(in_sref_o), 1);
        chk_eq("R11 count", longint'(sref_cnt_o), m_cnt);
        @(negedge clk);
        chk_eq("R11 done", longint'(done_o), 1);
        chk_eq("R11 err", longint'(err_state_o), 0);
        check_buckets("R11");
        do_exit(t + 108 + 12, 1'b1);              // measured from the new stamp

        // Entry in the commit cycle of an exit
        t += 300;
        do_enter(t);
        @(negedge clk);
        exit_i = 1'b1; ts_i = TS_W'(t + 5); dll_en_i = 1'b1;
        model_exit(t + 5, 1'b1, wz, wc, er);
        m_in = 0;
        @(negedge clk);
        exit_i = 1'b0; enter_i = 1'b1; ts_i = TS_W'(t + 9);
        @(negedge clk);
        enter_i = 1'b0;
        m_entry = t + 9; m_cnt++; m_in = 1;
        chk_eq("R3 done with entry", longint'(done_o), 1);
        chk_eq("R5 warn_ckesr with entry", longint'(warn_ckesr_o), longint'(wc));
        check_buckets("R8 commit with entry");
        chk_eq("R2 entry in commit", longint'(in_sref_o), 1);
        chk_eq("R2 count in commit", longint'(sref_cnt_o), m_cnt);
        do_exit(t + 9 + 8, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule